// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block sits beside a root port and turns inbound memory writes aimed at one programmed 64-bit address into latched interrupt requests. Each such write carries a vector number as its data; that number picks one bit out of a set of 32-bit banks, and the chosen bit is latched in the bank's pending (status) word. Software reads the pending words, services the vectors it finds, and clears them by writing ones back.

Each bank has three control words: an enable word that decides which vectors may latch at all, a mask word that hides latched vectors from the interrupt line, and the pending word itself. The number of banks is a parameter, with eight banks (256 vectors) by default. A single level interrupt output is high for as long as any bank holds a pending bit whose mask bit is clear. Extended-table interrupts, packet parsing and the policy for handing out vectors are left to other logic.

Top module: `msi_collector`

## Requirements
- R1: After reset every readable word (target low and high, and each bank's enable, mask and pending word) reads 0 and `irq` is low.
- R2: The target address is written 32 bits at a time, its lower half at byte offset 0x820 and its upper half at 0x824, and reads back at the same offsets; it changes only on such a write.
- R3: A cycle with `msg_valid` high, `msg_addr` equal to the target and `msg_data` below 32 times the bank count sets pending bit `msg_data` mod 32 of bank `msg_data` div 32 at the next clock edge, and sets no other bit.
- R4: A vector whose enable bit is 0 in the cycle of the message is not latched.
- R5: `irq` equals the OR over all banks of (pending AND NOT mask), following the registers in the same cycle; a mask bit never stops a vector from latching.
- R6: Writing the pending word clears each bit written as 1 and leaves each bit written as 0; the enable and mask words take the written value whole.
- R7: A message whose address differs from the target in any of its 64 bits, or whose data is 32 times the bank count or more, changes no state.
- R8: Bank b places its enable word at byte offset 0x828 + 12*b, its mask word 4 bytes above that and its pending word 8 bytes above that.
- R9: When a message and a clearing write hit the same pending bit in one cycle, the bit is set afterwards.
- R10: Any offset not named in R2 or R8, unaligned ones included, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An inbound memory write is presented this cycle |
| msg_addr | input | 64 | Address of the inbound write |
| msg_data | input | MSG_DATA_W | Data of the inbound write, taken as vector number |
| csr_wen | input | 1 | Register write strobe |
| csr_addr | input | RADDR_W | Byte offset of the register access |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr`, combinational |
| irq | output | 1 | Level interrupt: some unmasked pending bit is set |

## Verification
The bench aims at the edges of the vector range: vector 255 must land in the last bank, and vector 256 must be dropped rather than wrap to vector 0, which a design that truncated the data would latch. It sends messages that differ from the target only in the upper address word, catching a compare that looks at one half only. It drives a message and a clearing write at the same bit in one cycle, where a design that ordered clear after set would lose the interrupt, and it checks that a masked vector still latches so that unmasking later raises the line. Reads at the bank stride, between words and past the last bank catch a decoder that uses the wrong spacing or aliases offsets.

// File: rtl/msi_pkg.sv
package msi_pkg;

   localparam int unsigned CSR_W         = 32;
   localparam int unsigned VEC_PER_BANK  = 32;
   localparam int unsigned LANE_W        = 5;

   localparam int unsigned OFF_TGT_LO    = 'h820;
   localparam int unsigned OFF_TGT_HI    = 'h824;
   localparam int unsigned OFF_BANK_BASE = 'h828;
   localparam int unsigned BANK_STRIDE   = 12;

   typedef enum logic [1:0] {
      FLD_ENABLE = 2'd0,
      FLD_MASK   = 2'd1,
      FLD_STATUS = 2'd2
   } bank_field_e;

   function automatic int unsigned bank_word_offset(int unsigned bank, bank_field_e fld);
      return OFF_BANK_BASE + BANK_STRIDE * bank + 4 * int'(fld);
   endfunction

endpackage

// File: rtl/msi_target_match.sv
module msi_target_match #(
   parameter int unsigned CSR_W      = 32,
   parameter int unsigned MSG_DATA_W = 32,
   parameter int unsigned NUM_VEC    = 256,
   parameter int unsigned VIDX_W     = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_lo,
   input  logic                    wr_hi,
   input  logic [CSR_W-1:0]        wdata,
   input  logic                    msg_valid,
   input  logic [2*CSR_W-1:0]      msg_addr,
   input  logic [MSG_DATA_W-1:0]   msg_data,
   output logic [2*CSR_W-1:0]      target_q,
   output logic                    hit,
   output logic [VIDX_W-1:0]       vec_idx
);

   localparam logic [MSG_DATA_W-1:0] VEC_LIMIT = MSG_DATA_W'(NUM_VEC);

   if (MSG_DATA_W < VIDX_W) begin : g_bad_width
      $error("msi_target_match: MSG_DATA_W too narrow for the vector index");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target_q <= '0;
      end else begin
         if (wr_lo) target_q[CSR_W-1:0]       <= wdata;
         if (wr_hi) target_q[2*CSR_W-1:CSR_W] <= wdata;
      end
   end

   logic lo_eq, hi_eq, data_ok;

   assign lo_eq   = (msg_addr[CSR_W-1:0] == target_q[CSR_W-1:0]);
   assign hi_eq   = (msg_addr[2*CSR_W-1:CSR_W] == target_q[2*CSR_W-1:CSR_W]);
   assign data_ok = (msg_data < VEC_LIMIT);
   assign hit     = msg_valid & lo_eq & hi_eq & data_ok;
   assign vec_idx = msg_data[VIDX_W-1:0];

endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
   parameter int unsigned LANES = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_enable,
   input  logic             wr_mask,
   input  logic             wr_status,
   input  logic [LANES-1:0] wdata,
   input  logic [LANES-1:0] set_req,
   output logic [LANES-1:0] enable_q,
   output logic [LANES-1:0] mask_q,
   output logic [LANES-1:0] status_q,
   output logic             pend
);

   logic [LANES-1:0] clr_bits;
   logic [LANES-1:0] set_bits;

   assign clr_bits = wr_status ? wdata : '0;
   assign set_bits = set_req & enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
         mask_q   <= '0;
         status_q <= '0;
      end else begin
         if (wr_enable) enable_q <= wdata;
         if (wr_mask)   mask_q   <= wdata;
         status_q <= (status_q & ~clr_bits) | set_bits;
      end
   end

   assign pend = |(status_q & ~mask_q);

endmodule

// File: rtl/msi_pend_or.sv
module msi_pend_or #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] pend,
   output logic         any
);

   localparam int unsigned HALF = N / 2;

   if (N == 1) begin : g_leaf
      assign any = pend[0];
   end else begin : g_split
      logic lo_any, hi_any;
      msi_pend_or #(.N(HALF))     u_lo (.pend(pend[HALF-1:0]), .any(lo_any));
      msi_pend_or #(.N(N - HALF)) u_hi (.pend(pend[N-1:HALF]), .any(hi_any));
      assign any = lo_any | hi_any;
   end

endmodule

// File: rtl/msi_collector.sv
module msi_collector
   import msi_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 8,
   parameter int unsigned MSG_DATA_W = 32,
   parameter int unsigned RADDR_W    = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  msg_valid,
   input  logic [63:0]           msg_addr,
   input  logic [MSG_DATA_W-1:0] msg_data,
   input  logic                  csr_wen,
   input  logic [RADDR_W-1:0]    csr_addr,
   input  logic [31:0]           csr_wdata,
   output logic [31:0]           csr_rdata,
   output logic                  irq
);

   localparam int unsigned NUM_VEC    = NUM_BANKS * VEC_PER_BANK;
   localparam int unsigned BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int unsigned VIDX_W     = LANE_W + BANK_SEL_W;
   localparam int unsigned ADDR_SPAN  = 1 << RADDR_W;

   if (NUM_BANKS < 1 || NUM_BANKS > 64) begin : g_bad_banks
      $error("msi_collector: NUM_BANKS must lie in 1..64");
   end
   if (OFF_BANK_BASE + BANK_STRIDE * NUM_BANKS > ADDR_SPAN) begin : g_bad_span
      $error("msi_collector: register window too small for NUM_BANKS");
   end

   logic                       tgt_wr_lo, tgt_wr_hi;
   logic [63:0]                target_q;
   logic                       msg_hit;
   logic [VIDX_W-1:0]          vec_idx;
   logic [NUM_BANKS*CSR_W-1:0] status_all;
   logic [NUM_BANKS*CSR_W-1:0] en_all;
   logic [NUM_BANKS-1:0]       bank_pend;
   logic [CSR_W-1:0]           bank_rd [NUM_BANKS];
   logic [CSR_W-1:0]           tgt_rd;

   assign tgt_wr_lo = csr_wen && (csr_addr == RADDR_W'(OFF_TGT_LO));
   assign tgt_wr_hi = csr_wen && (csr_addr == RADDR_W'(OFF_TGT_HI));

   msi_target_match #(
      .CSR_W      (CSR_W),
      .MSG_DATA_W (MSG_DATA_W),
      .NUM_VEC    (NUM_VEC),
      .VIDX_W     (VIDX_W)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (tgt_wr_lo),
      .wr_hi     (tgt_wr_hi),
      .wdata     (csr_wdata),
      .msg_valid (msg_valid),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data),
      .target_q  (target_q),
      .hit       (msg_hit),
      .vec_idx   (vec_idx)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned OFF_EN = bank_word_offset(b, FLD_ENABLE);
      localparam int unsigned OFF_MK = bank_word_offset(b, FLD_MASK);
      localparam int unsigned OFF_ST = bank_word_offset(b, FLD_STATUS);

      logic             sel_en, sel_mk, sel_st;
      logic             bank_hit;
      logic [CSR_W-1:0] set_req;
      logic [CSR_W-1:0] en_q, mk_q, st_q;

      assign sel_en   = (csr_addr == RADDR_W'(OFF_EN));
      assign sel_mk   = (csr_addr == RADDR_W'(OFF_MK));
      assign sel_st   = (csr_addr == RADDR_W'(OFF_ST));
      assign bank_hit = msg_hit && (vec_idx[VIDX_W-1:LANE_W] == BANK_SEL_W'(b));
      assign set_req  = bank_hit ? (CSR_W'(1) << vec_idx[LANE_W-1:0]) : '0;

      msi_bank #(.LANES(CSR_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_enable (csr_wen && sel_en),
         .wr_mask   (csr_wen && sel_mk),
         .wr_status (csr_wen && sel_st),
         .wdata     (csr_wdata),
         .set_req   (set_req),
         .enable_q  (en_q),
         .mask_q    (mk_q),
         .status_q  (st_q),
         .pend      (bank_pend[b])
      );

      assign status_all[b*CSR_W +: CSR_W] = st_q;
      assign en_all[b*CSR_W +: CSR_W]     = en_q;
      assign bank_rd[b] = ({CSR_W{sel_en}} & en_q)
                        | ({CSR_W{sel_mk}} & mk_q)
                        | ({CSR_W{sel_st}} & st_q);
   end

   assign tgt_rd = ((csr_addr == RADDR_W'(OFF_TGT_LO)) ? target_q[31:0]  : '0)
                 | ((csr_addr == RADDR_W'(OFF_TGT_HI)) ? target_q[63:32] : '0);

   always_comb begin
      csr_rdata = tgt_rd;
      for (int b = 0; b < NUM_BANKS; b++) begin
         csr_rdata = csr_rdata | bank_rd[b];
      end
   end

   msi_pend_or #(.N(NUM_BANKS)) u_pend_or (
      .pend (bank_pend),
      .any  (irq)
   );

endmodule

// File: rtl/msi_collector_chk.sv
module msi_collector_chk #(
   parameter int unsigned NUM_BANKS = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    msg_valid,
   input logic                    csr_wen,
   input logic                    irq,
   input logic [NUM_BANKS*32-1:0] status_all,
   input logic [NUM_BANKS*32-1:0] en_all,
   input logic [63:0]             target_q
);

   AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (status_all & ~$past(status_all) & ~$past(en_all)) == '0); // R4

   AST_SET_NEEDS_MESSAGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_all & ~$past(status_all)) != '0) |-> $past(msg_valid)); // R3

   AST_ONE_VECTOR_PER_MESSAGE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status_all & ~$past(status_all)) <= 1); // R3

   AST_IRQ_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (status_all == '0) |-> !irq); // R5

   AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(csr_wen) |-> $stable(target_q)); // R2

endmodule

bind msi_collector msi_collector_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .msg_valid  (msg_valid),
   .csr_wen    (csr_wen),
   .irq        (irq),
   .status_all (status_all),
   .en_all     (en_all),
   .target_q   (target_q)
);

// File: tb/msi_collector_bench.sv
`timescale 1ns/1ps
module msi_collector_bench;

   localparam int NB = 8;
   localparam int NV = NB * 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        msg_valid;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;
   logic        csr_wen;
   logic [11:0] csr_addr;
   logic [31:0] csr_wdata;
   logic [31:0] csr_rdata;
   logic        irq;

   always #10 clk = ~clk;

   msi_collector u_msi_collector (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_valid (msg_valid),
      .msg_addr  (msg_addr),
      .msg_data  (msg_data),
      .csr_wen   (csr_wen),
      .csr_addr  (csr_addr),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .irq       (irq)
   );

   // reference state
   logic [31:0] m_en [NB];
   logic [31:0] m_mk [NB];
   logic [31:0] m_st [NB];
   logic [63:0] m_tgt;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [63:0] TGT = 64'h0000_0001_FEE0_1000;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // decode of an offset into (kind, bank, field); kind 1=lo 2=hi 3=bank 0=none
   function automatic int decode(int a, output int bank, output int fld);
      int d;
      bank = 0; fld = 0;
      if (a == 'h820) return 1;
      if (a == 'h824) return 2;
      if (a < 'h828) return 0;
      d = a - 'h828;
      if ((d % 12) % 4 != 0) return 0;
      if (d / 12 >= NB) return 0;
      bank = d / 12;
      fld  = (d % 12) / 4;
      return 3;
   endfunction

   function automatic logic [31:0] m_read(int a);
      int b, f, k;
      k = decode(a, b, f);
      case (k)
         1: return m_tgt[31:0];
         2: return m_tgt[63:32];
         3: return (f == 0) ? m_en[b] : (f == 1) ? m_mk[b] : m_st[b];
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic m_irq();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r = r | (|(m_st[b] & ~m_mk[b]));
      return r;
   endfunction

   // one clock: drive at negedge, predict, commit after the edge, compare irq
   task automatic step(bit wen, int waddr, logic [31:0] wd, bit mv, logic [63:0] ma, logic [31:0] md);
      logic [31:0] n_en [NB];
      logic [31:0] n_mk [NB];
      logic [31:0] n_st [NB];
      logic [63:0] n_tgt;
      int b, f, k;
      csr_wen   = wen;
      csr_addr  = 12'(waddr);
      csr_wdata = wd;
      msg_valid = mv;
      msg_addr  = ma;
      msg_data  = md;
      n_en = m_en; n_mk = m_mk; n_st = m_st; n_tgt = m_tgt;
      if (wen) begin
         k = decode(waddr, b, f);
         if (k == 1) n_tgt[31:0] = wd;
         if (k == 2) n_tgt[63:32] = wd;
         if (k == 3) begin
            if (f == 0) n_en[b] = wd;
            if (f == 1) n_mk[b] = wd;
            if (f == 2) n_st[b] = m_st[b] & ~wd;
         end
      end
      if (mv && ma == m_tgt && md < NV) begin
         if (m_en[md / 32][md % 32]) n_st[md / 32][md % 32] = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      m_en = n_en; m_mk = n_mk; m_st = n_st; m_tgt = n_tgt;
      csr_wen   = 1'b0;
      msg_valid = 1'b0;
      chk("R5", "irq", 64'(irq), 64'(m_irq()));
   endtask

   task automatic wr(int a, logic [31:0] d);
      step(1'b1, a, d, 1'b0, 64'h0, 32'h0);
   endtask

   task automatic msg(logic [63:0] a, logic [31:0] d);
      step(1'b0, 0, 32'h0, 1'b1, a, d);
   endtask

   task automatic rd(int a, string req, logic [31:0] exp);
      csr_addr = 12'(a);
      #1;
      chk(req, $sformatf("read %h", a), 64'(csr_rdata), 64'(exp));
      chk(req, $sformatf("model %h", a), 64'(csr_rdata), 64'(m_read(a)));
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; msg_valid = 1'b0; msg_addr = '0; msg_data = '0;
      csr_wen = 1'b0; csr_addr = '0; csr_wdata = '0;
      for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_mk[b] = '0; m_st[b] = '0; end
      m_tgt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1", "irq after reset", 64'(irq), 64'h0);
      rd('h820, "R1", 32'h0);
      rd('h824, "R1", 32'h0);
      for (int b = 0; b < NB; b++) begin
         rd('h828 + 12*b, "R1", 32'h0);
         rd('h82C + 12*b, "R1", 32'h0);
         rd('h830 + 12*b, "R1", 32'h0);
      end

      // R2 target programming
      wr('h820, TGT[31:0]);
      wr('h824, TGT[63:32]);
      rd('h820, "R2", 32'hFEE0_1000);
      rd('h824, "R2", 32'h0000_0001);

      // R3 enabled vector latches
      wr('h828, 32'h0000_0005);
      rd('h828, "R6", 32'h0000_0005);
      msg(TGT, 32'd2);
      rd('h830, "R3", 32'h0000_0004);
      chk("R3", "irq raised", 64'(irq), 64'h1);

      // R4 disabled vector ignored
      msg(TGT, 32'd1);
      rd('h830, "R4", 32'h0000_0004);

      // R5 mask hides but latching continues
      wr('h82C, 32'h0000_0005);
      chk("R5", "masked irq", 64'(irq), 64'h0);
      msg(TGT, 32'd0);
      rd('h830, "R5", 32'h0000_0005);
      chk("R5", "masked after latch", 64'(irq), 64'h0);

      // R6 write-one-to-clear
      wr('h830, 32'h0000_0001);
      rd('h830, "R6", 32'h0000_0004);
      wr('h830, 32'h0000_0000);
      rd('h830, "R6", 32'h0000_0004);
      wr('h82C, 32'h0000_0000);
      chk("R5", "unmasked irq", 64'(irq), 64'h1);
      wr('h830, 32'h0000_0004);
      chk("R6", "irq after clear", 64'(irq), 64'h0);

      // R7 address mismatch in upper word, data out of range
      msg({32'h0000_0002, TGT[31:0]}, 32'd0);
      rd('h830, "R7", 32'h0);
      msg({TGT[63:32], 32'hFEE0_1004}, 32'd0);
      rd('h830, "R7", 32'h0);
      msg(TGT, 32'd256);
      rd('h830, "R7", 32'h0);
      chk("R7", "irq after ignored", 64'(irq), 64'h0);

      // R8 bank stride: vector 100 -> bank 3 bit 4
      wr('h828 + 36, 32'hFFFF_FFFF);
      msg(TGT, 32'd100);
      rd('h830 + 36, "R8", 32'h0000_0010);
      rd('h830, "R8", 32'h0);

      // R9 set and clear of the same bit together
      wr('h830 + 36, 32'h0000_0010);
      rd('h830 + 36, "R9", 32'h0);
      step(1'b1, 'h830 + 36, 32'h0000_0010, 1'b1, TGT, 32'd100);
      rd('h830 + 36, "R9", 32'h0000_0010);
      wr('h830 + 36, 32'hFFFF_FFFF);

      // R8 last vector lands in last bank
      wr('h828 + 84, 32'h8000_0000);
      msg(TGT, 32'd255);
      rd('h830 + 84, "R8", 32'h8000_0000);
      wr('h830 + 84, 32'h8000_0000);

      // R10 unmapped offsets
      wr('h828 + 12*NB, 32'hFFFF_FFFF);
      wr('h82A, 32'hFFFF_FFFF);
      rd('h828 + 12*NB, "R10", 32'h0);
      rd('h82A, "R10", 32'h0);
      rd('h81C, "R10", 32'h0);
      rd('h828, "R10", 32'h0000_0005);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         int kind, b, f, v;
         logic [63:0] a;
         kind = $urandom % 4;
         b = $urandom % NB;
         f = $urandom % 3;
         v = $urandom % 300;
         a = ($urandom % 8 == 0) ? (TGT ^ 64'h0000_0001_0000_0000) : TGT;
         case (kind)
            0: step(1'b1, 'h828 + 12*b + 4*f, $urandom, 1'b0, 64'h0, 32'h0);
            1: step(1'b0, 0, 32'h0, 1'b1, a, 32'(v));
            2: step(1'b1, 'h830 + 12*b, $urandom, 1'b1, a, 32'(v));
            default: step(1'b0, 0, 32'h0, 1'b0, 64'h0, 32'h0);
         endcase
         v = 'h828 + 12*($urandom % NB) + 4*($urandom % 3);
         csr_addr = 12'(v);
         #1;
         chk("R3", "mixed read", 64'(csr_rdata), 64'(m_read(v)));
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule